// File: doc/BRIEF.md
# I2C Target Controller with Receive and Transmit Ring Buffers

This block answers as a target on an I2C bus with a 7-bit own address. SCL and SDA come in as raw line levels and are resampled on the system clock. The block drives both lines only through open-drain pull-down enables. It finds start, repeated-start and stop conditions and checks the address byte that follows each start. It then either takes bytes from the bus controller or hands bytes to it. It also answers the all-zero general-call byte as a write.

Bytes written by the bus controller go into a receive ring buffer. A local consumer drains that buffer through a valid/ready stream. A byte moves when `rx_valid` and `rx_ready` are both high at a clock edge. `rx_data` holds steady while `rx_valid` is high and no pop has taken place. Bytes for the bus controller to read come from a transmit ring buffer. A local producer fills that buffer through a second valid/ready stream. The producer must hold `tx_valid` and `tx_data` until `tx_ready` is high. `tx_ready` is low only while the buffer is full and the engine is not taking a byte out in the same cycle.

When the receive buffer is full at the end of a byte, the block holds SCL low until the consumer frees a slot. A one-cycle `flush` pulse empties both buffers.

Top module: `i2c_tgt_ringbuf`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are low, `rx_valid` is low and `tx_ready` is high.
- R2: The block acknowledges (pulls SDA low during the ninth clock) an address byte after a start in two cases: its upper seven bits equal `own_addr`, or the whole byte is 0x00. Bit 0 of the byte gives the direction: 0 means the bus controller writes, 1 means it reads.
- R3: The block does not acknowledge an address byte that fails both tests. It then ignores all clocks and data until the next start.
- R4: In a write transfer, each byte is shifted in MSB first on SCL rising edges and stored in the receive buffer in arrival order. The block acknowledges each byte, and this repeats until a stop or a start.
- R5: In a read transfer, each byte is taken from the transmit buffer in push order and shifted out MSB first. `sda_oe` only rises while SCL is low.
- R6: When the transmit buffer is empty at the start of a read byte, the block releases SDA and returns to idle, so the bus controller reads 0xFF.
- R7: A high level (NACK) sampled in the acknowledge slot after a transmitted byte ends the transfer, and no further byte is taken. A low level (ACK) goes on to the next byte.
- R8: A start seen in the middle of a transfer restarts address checking. Bytes already stored are kept.
- R9: After a start, bit counting begins only once SCL is low. A stop seen while waiting for SCL to go low abandons the start, and the block stays idle.
- R10: Each ring buffer of depth 2^AW holds at most 2^AW-1 bytes. With 2^AW-1 bytes in the transmit buffer and no engine pop in that cycle, `tx_ready` is low.
- R11: If the receive buffer is full when a byte completes, the block holds SCL low. It stores the byte and acknowledges it once the consumer pops, and the store may fall in the same cycle as the pop.
- R12: A `flush` pulse empties both buffers. In the next cycle `rx_valid` is low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Own 7-bit target address |
| flush | input | 1 | Empty both ring buffers |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| rx_valid | output | 1 | Receive buffer holds at least one byte |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| rx_data | output | 8 | Oldest received byte |
| tx_valid | input | 1 | Producer offers `tx_data` |
| tx_ready | output | 1 | Transmit buffer accepts a byte |
| tx_data | input | 8 | Byte to queue for reading |

## Verification
The consumer's pop and the engine's store of a held byte can land in the same clock cycle. This happens when the receive buffer is full and SCL is being stretched, because the store uses the slot the pop frees. The bench fills the receive buffer to capacity and then sends one more byte. It checks that SCL stays low until a single pop, and then checks that the extra byte is acknowledged. The drained bytes must come out in arrival order with the held byte last, and nothing may be lost or duplicated.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BYTE_EDGES = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(BYTE_EDGES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_AACK,
    ST_RXB,
    ST_RXH,
    ST_RXA,
    ST_TXL,
    ST_TXB,
    ST_TXA
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] lvl_q;

  assign raw = {sda_i, scl_i};

  for (genvar ln = 0; ln < 2; ln++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[ln]};
    end
    assign lvl[ln] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_s    = lvl[0];
  assign sda_s    = lvl[1];
  assign scl_rise = lvl[0] & ~lvl_q[0];
  assign scl_fall = ~lvl[0] & lvl_q[0];
  // SDA moving while SCL stays high marks a bus condition
  assign start_ev = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
  assign stop_ev  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/i2c_tgt_ring.sv
module i2c_tgt_ring #(
  parameter int AW = 3,
  parameter int W  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] head, tail, head_nx, tail_nx;
  logic [W-1:0]  mem [DEPTH];
  logic          empty, full, push, pop;

  assign head_nx   = head + 1'b1;
  assign tail_nx   = tail + 1'b1;
  assign empty     = (head == tail);
  assign full      = (head_nx == tail);
  assign out_valid = ~empty;
  // a pop in the same cycle frees the slot a push needs
  assign in_ready  = ~full | out_ready;
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[tail];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (push) head <= head_nx;
      if (pop)  tail <= tail_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[head] <= in_data;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              rx_wr_valid,
  input  logic              rx_wr_ready,
  output logic [BYTE_W-1:0] rx_wr_data,
  input  logic              tx_rd_valid,
  output logic              tx_rd_ready,
  input  logic [BYTE_W-1:0] tx_rd_data,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(BYTE_EDGES - 1);
  localparam logic [EDGE_W-1:0] ACK_EDGE  = EDGE_W'(1);

  tgt_state_t        st;
  logic [EDGE_W-1:0] cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rd_dir;
  logic              ack_smp;
  logic              byte_done;
  logic              slot_done;
  logic              addr_hit;

  assign byte_done   = scl_fall && (cnt == LAST_EDGE);
  assign slot_done   = scl_fall && (cnt == ACK_EDGE);
  assign addr_hit    = (rx_sh == '0) || (rx_sh[BYTE_W-1:1] == own_addr);
  assign rx_wr_valid = (st == ST_RXH) || ((st == ST_RXB) && byte_done);
  assign rx_wr_data  = rx_sh;
  assign tx_rd_ready = (st == ST_TXL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rd_dir  <= 1'b0;
      ack_smp <= 1'b1;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_START;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_rise || scl_fall) cnt <= cnt + 1'b1;
      if (scl_rise) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
      unique case (st)
        ST_IDLE: ;
        ST_START: begin
          if (!scl_s) begin
            st  <= ST_ADDR;
            cnt <= '0;
          end
        end
        ST_ADDR: begin
          if (byte_done) begin
            cnt <= '0;
            if (addr_hit) begin
              rd_dir <= rx_sh[0];
              sda_oe <= 1'b1;
              st     <= ST_AACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (slot_done) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= rd_dir ? ST_TXL : ST_RXB;
          end
        end
        ST_RXB: begin
          if (byte_done) begin
            cnt <= '0;
            if (rx_wr_ready) begin
              sda_oe <= 1'b1;
              st     <= ST_RXA;
            end else begin
              scl_oe <= 1'b1;
              st     <= ST_RXH;
            end
          end
        end
        ST_RXH: begin
          if (rx_wr_ready) begin
            sda_oe <= 1'b1;
            cnt    <= '0;
            st     <= ST_RXA;
          end
        end
        ST_RXA: begin
          // SDA is already low; let SCL go one cycle later
          if (scl_oe) scl_oe <= 1'b0;
          if (slot_done) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_RXB;
          end
        end
        ST_TXL: begin
          cnt <= '0;
          if (tx_rd_valid) begin
            tx_sh  <= tx_rd_data;
            sda_oe <= ~tx_rd_data[BYTE_W-1];
            st     <= ST_TXB;
          end else begin
            sda_oe <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_TXB: begin
          if (byte_done) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_TXA;
          end else if (scl_fall) begin
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~tx_sh[BYTE_W-2];
          end
        end
        ST_TXA: begin
          if (scl_rise) ack_smp <= sda_s;
          if (slot_done) begin
            cnt <= '0;
            st  <= ack_smp ? ST_IDLE : ST_TXL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_ringbuf.sv
module i2c_tgt_ringbuf
  import i2c_tgt_pkg::*;
#(
  parameter int RX_AW = 3,
  parameter int TX_AW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              flush,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic rx_wr_valid, rx_wr_ready;
  logic tx_rd_valid, tx_rd_ready;
  logic [BYTE_W-1:0] rx_wr_data, tx_rd_data;
  logic rx_wr_fire, tx_pop;

  assign rx_wr_fire = rx_wr_valid & rx_wr_ready;
  assign tx_pop     = tx_rd_valid & tx_rd_ready;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_tgt_engine eng_i (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .rx_wr_valid(rx_wr_valid), .rx_wr_ready(rx_wr_ready), .rx_wr_data(rx_wr_data),
    .tx_rd_valid(tx_rd_valid), .tx_rd_ready(tx_rd_ready), .tx_rd_data(tx_rd_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c_tgt_ring #(.AW(RX_AW), .W(BYTE_W)) rx_ring_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(rx_wr_valid), .in_ready(rx_wr_ready), .in_data(rx_wr_data),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  i2c_tgt_ring #(.AW(TX_AW), .W(BYTE_W)) tx_ring_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tx_rd_valid), .out_ready(tx_rd_ready), .out_data(tx_rd_data)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int RX_AW = 3,
  parameter int TX_AW = 3
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_wr_fire,
  input logic tx_pop
);
  localparam int RX_MAX = (1 << RX_AW) - 1;
  localparam int TX_MAX = (1 << TX_AW) - 1;

  int rx_cnt, tx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= 0;
      tx_cnt <= 0;
    end else if (flush) begin
      rx_cnt <= 0;
      tx_cnt <= 0;
    end else begin
      rx_cnt <= rx_cnt + int'(rx_wr_fire) - int'(rx_valid && rx_ready);
      tx_cnt <= tx_cnt + int'(tx_valid && tx_ready) - int'(tx_pop);
    end
  end

  // R10: neither buffer ever holds more than depth-1 bytes
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= RX_MAX) && (tx_cnt <= TX_MAX));

  // R10: full transmit buffer without an engine pop refuses the producer
  a_r10_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == TX_MAX && !tx_pop) |-> !tx_ready);

  // R12: flush leaves both buffers empty
  a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rx_valid && tx_ready));

  // R5: SDA is only pulled down while SCL is low
  a_r5_sda_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R11: a stretch starts only after the receive buffer was full
  a_r11_stretch_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(rx_cnt == RX_MAX));
endmodule

bind i2c_tgt_ringbuf i2c_tgt_chk #(.RX_AW(RX_AW), .TX_AW(TX_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .scl_i(scl_i),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_wr_fire(rx_wr_fire), .tx_pop(tx_pop)
);

// File: tb/i2c_tgt_ringbuf_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_ringbuf_tb_top;
  localparam int HALF = 20;
  localparam int CAP  = 7;
  localparam logic [6:0] OWN = 7'h3A;
  localparam logic [7:0] AW_WR = {OWN, 1'b0};
  localparam logic [7:0] AW_RD = {OWN, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic scl_m_low = 1'b0;
  logic sda_m_low = 1'b0;
  logic rx_ready = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic scl_oe, sda_oe, rx_valid, tx_ready;
  logic [7:0] rx_data;
  logic scl_line, sda_line;
  int total = 0;
  int bad = 0;
  int viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_line = ~(scl_m_low | scl_oe);
  assign sda_line = ~(sda_m_low | sda_oe);

  i2c_tgt_ringbuf dut_i (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .flush(flush),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  // counts target SDA changes seen while SCL is high
  logic sda_oe_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_line && (sda_oe !== sda_oe_q)) viol++;
    sda_oe_q <= sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m_low = ~b;
    wclk(HALF);
    scl_m_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wclk(HALF / 2);
    r = sda_line;
    wclk(HALF / 2);
    scl_m_low = 1'b1;
    wclk(HALF);
  endtask

  task automatic m_start();
    sda_m_low = 1'b0;
    wclk(HALF);
    scl_m_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wclk(HALF);
    sda_m_low = 1'b1;
    wclk(HALF);
    scl_m_low = 1'b1;
    wclk(HALF);
  endtask

  task automatic m_stop();
    sda_m_low = 1'b1;
    wclk(HALF);
    scl_m_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wclk(HALF);
    sda_m_low = 1'b0;
    wclk(HALF);
  endtask

  task automatic m_write(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ack);
  endtask

  task automatic m_read(output logic [7:0] d, input logic nack);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(nack, r);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check({tag, " valid"}, rx_valid, 1'b1);
    check(tag, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 scl_oe", scl_oe, 1'b0);
    check("R1 sda_oe", sda_oe, 1'b0);
    check("R1 rx_valid", rx_valid, 1'b0);
    check("R1 tx_ready", tx_ready, 1'b1);
  endtask

  task automatic t_write();
    logic a;
    m_start();
    m_write(AW_WR, a);  check("R2 own address ack", a, 1'b0);
    m_write(8'hC3, a);  check("R4 byte0 ack", a, 1'b0);
    m_write(8'h5A, a);  check("R4 byte1 ack", a, 1'b0);
    m_stop();
    pop_chk("R4 byte0", 8'hC3);
    pop_chk("R4 byte1", 8'h5A);
    wclk(2);
    check("R4 drained", rx_valid, 1'b0);
  endtask

  task automatic t_gcall();
    logic a;
    m_start();
    m_write(8'h00, a);  check("R2 general call ack", a, 1'b0);
    m_write(8'h96, a);  check("R2 general call data ack", a, 1'b0);
    m_stop();
    pop_chk("R2 general call data", 8'h96);
  endtask

  task automatic t_mismatch();
    logic a;
    m_start();
    m_write({OWN ^ 7'h01, 1'b0}, a);  check("R3 foreign address nack", a, 1'b1);
    m_write(8'h00, a);                check("R3 later byte ignored", a, 1'b1);
    m_stop();
    wclk(4);
    check("R3 nothing stored", rx_valid, 1'b0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    push(8'hA5);
    push(8'h3C);
    m_start();
    m_write(AW_RD, a);  check("R2 read address ack", a, 1'b0);
    m_read(d, 1'b0);    check("R5 first read", d, 8'hA5);
    m_read(d, 1'b1);    check("R5 second read", d, 8'h3C);
    m_stop();
    check("R5 target released", sda_oe, 1'b0);
    check("R5 no SDA change with SCL high", viol, 0);
  endtask

  task automatic t_empty();
    logic a;
    logic [7:0] d;
    m_start();
    m_write(AW_RD, a);  check("R6 ack with empty buffer", a, 1'b0);
    m_read(d, 1'b1);    check("R6 empty reads 0xFF", d, 8'hFF);
    m_stop();
    push(8'h42);
    m_start();
    m_write(AW_RD, a);
    m_read(d, 1'b0);    check("R6 last byte", d, 8'h42);
    m_read(d, 1'b1);    check("R6 runs dry", d, 8'hFF);
    m_stop();
    check("R6 SDA released", sda_oe, 1'b0);
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] d;
    push(8'h11);
    push(8'h22);
    push(8'h33);
    m_start();
    m_write(AW_RD, a);
    m_read(d, 1'b1);    check("R7 byte before nack", d, 8'h11);
    m_stop();
    m_start();
    m_write(AW_RD, a);
    m_read(d, 1'b0);    check("R7 nack left next byte", d, 8'h22);
    m_read(d, 1'b1);    check("R7 ack moved on", d, 8'h33);
    m_stop();
  endtask

  task automatic t_rstart();
    logic a;
    logic [7:0] d;
    push(8'h77);
    m_start();
    m_write(AW_WR, a);
    m_write(8'h19, a);  check("R8 write before restart", a, 1'b0);
    m_start();
    m_write(AW_RD, a);  check("R8 address after restart", a, 1'b0);
    m_read(d, 1'b1);    check("R8 read after restart", d, 8'h77);
    m_stop();
    pop_chk("R8 kept byte", 8'h19);
  endtask

  task automatic t_abort();
    logic a;
    sda_m_low = 1'b1;
    wclk(HALF);
    sda_m_low = 1'b0;
    wclk(HALF);
    scl_m_low = 1'b1;
    wclk(HALF);
    m_write(AW_WR, a);  check("R9 abandoned start no ack", a, 1'b1);
    m_stop();
    wclk(4);
    check("R9 nothing stored", rx_valid, 1'b0);
  endtask

  task automatic t_full_flush();
    logic a;
    logic [7:0] d;
    int n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!tx_ready) break;
      tx_valid = 1'b1;
      tx_data  = 8'(i);
      @(negedge clk);
      tx_valid = 1'b0;
      n++;
    end
    check("R10 capacity", n, CAP);
    check("R10 tx_ready low when full", tx_ready, 1'b0);
    pulse_flush();
    check("R12 tx_ready after flush", tx_ready, 1'b1);
    m_start();
    m_write(AW_RD, a);
    m_read(d, 1'b1);    check("R12 flushed tx empty", d, 8'hFF);
    m_stop();
    m_start();
    m_write(AW_WR, a);
    m_write(8'hAA, a);
    m_stop();
    check("R12 rx holds byte", rx_valid, 1'b1);
    pulse_flush();
    check("R12 rx empty after flush", rx_valid, 1'b0);
  endtask

  task automatic t_stretch();
    logic a;
    logic a8 = 1'b1;
    m_start();
    m_write(AW_WR, a);
    for (int i = 0; i < CAP; i++) begin
      m_write(8'h60 + 8'(i), a);
      check("R11 fill ack", a, 1'b0);
    end
    fork
      m_write(8'hE7, a8);
      begin
        @(negedge clk);
        while (!scl_oe) @(negedge clk);
        wclk(100);
        check("R11 SCL held low", scl_line, 1'b0);
        pop_chk("R11 pop releases", 8'h60);
      end
    join
    check("R11 held byte acked", a8, 1'b0);
    m_stop();
    for (int i = 1; i < CAP; i++) pop_chk("R11 order", 8'h60 + 8'(i));
    pop_chk("R11 held byte last", 8'hE7);
    wclk(2);
    check("R11 drained", rx_valid, 1'b0);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_write();
    t_gcall();
    t_mismatch();
    t_read();
    t_empty();
    t_nack();
    t_rstart();
    t_abort();
    t_full_flush();
    t_stretch();
    check("R5 no SDA change with SCL high at end", viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule